// File: doc/BRIEF.md
# Sub-word Row Memory with Lane Select and Byte Reversal

This block is a small data memory organised as rows of eight bytes that serves byte-addressed loads and stores of 1, 2, 4 or 8 bytes through a single request port. The low address bits pick a byte lane within a row and the upper bits pick the row. A load pulls the addressed lanes out of the row and returns them right-aligned and zero-extended. A store narrower than a row reads the current row, replaces only the addressed lanes and writes the row back, all in one cycle. A full-row store simply overwrites the row.

Each access may optionally be byte-reversed over exactly its own width. Loads reverse after the lanes are extracted. Stores reverse before the data is merged. A request whose offset is not a multiple of its width is refused: an error flag pulses and memory is left as it was. Every row carries a valid bit that reset clears, so a row not written since reset reads as zero.

Top module: `sublane_mem`

## Requirements
- R1: The byte address splits into a byte offset (the low 3 bits) and a row index (the remaining upper bits). Byte lane k of a row occupies bits 8k+7..8k, and two addresses in the same row reach the same storage.
- R2: A request whose offset is not a multiple of the access width is misaligned. `rsp_misalign` is 1 in the cycle after a misaligned request and 0 after any other cycle. A misaligned request changes neither memory nor `rsp_rdata`.
- R3: An aligned load with `req_swap`=0 presents, one cycle after the request, the addressed lanes shifted down to bit 0, with all bits above the access width zero. The `req_size` encoding is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R4: An aligned store narrower than a row replaces only the addressed lanes and keeps all other lanes of the row. Bits of `req_wdata` above the access width are ignored.
- R5: An aligned 8-byte store replaces the whole row with `req_wdata`.
- R6: After reset, `rsp_rdata` and `rsp_misalign` are 0, and every row reads as zero until it is written again, even if it held data before the reset.
- R7: A load with `req_swap`=1 returns the extracted value with its bytes reversed over exactly the access width. The upper bits stay zero.
- R8: A store with `req_swap`=1 reverses the low width bytes of `req_wdata` before merging them into the row.
- R9: `rsp_rdata` holds its value in any cycle after a cycle with no request, or with a store.
- R10: Back-to-back requests to the same row see each other. A second sub-row store merges into the row as left by the first, and a load right after a store returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_swap | input | 1 | Byte-reverse the access over its width |
| req_wdata | input | DATA_W (64) | Store data, right-aligned |
| rsp_rdata | output | DATA_W (64) | Load data, one cycle after the request |
| rsp_misalign | output | 1 | One-cycle pulse after a refused request |

## Verification
Two functions can act on the same row in the same cycle. The read half of a sub-row store's read-modify-write samples the row that the previous cycle's store is still committing at that edge. Likewise, a load sees a row in the cycle right after a store wrote it. The bench provokes this with back-to-back narrow stores, with and without swap, into adjacent lanes of one row, followed at once by a full-row load. Random runs also issue requests with no idle gap. Each result is judged against a bench model of the rows that applies every store in request order. A lost or stale merge shows up as a wrong lane in the next load.

// File: rtl/sublane_pkg.sv
// Package: shared access-width encoding for the sub-word row memory.
// Assumes at most four width codes (1, 2, 4, 8 bytes).
package sublane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    // Number of bytes touched by a width code.
    function automatic int unsigned size_bytes(input logic [1:0] sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/sublane_align.sv
// Module: sublane_align
// Splits a byte address into row index and lane offset, derives the lane
// shift, the right-aligned width mask and the misalignment flag.
// Assumes ROW_BYTES is a power of two and the width code never exceeds a row.
module sublane_align #(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = ROW_W + OFF_W,
    localparam int DATA_W   = ROW_BYTES * 8,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [ROW_W-1:0]  row,
    output logic [SH_W-1:0]   shift,
    output logic [DATA_W-1:0] width_mask,
    output logic              misalign,
    output logic              full_row
);
    import sublane_pkg::*;

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] low_bits;

    // Purpose: address split and lane shift.
    always_comb begin
        row   = addr[ADDR_W-1:OFF_W];
        off   = addr[OFF_W-1:0];
        shift = {off, 3'b000};
    end

    // Purpose: build the width mask and the alignment test.
    always_comb begin
        for (int b = 0; b < ROW_BYTES; b++) begin
            width_mask[8*b +: 8] = (b < int'(size_bytes(size))) ? 8'hFF : 8'h00;
        end
        low_bits = OFF_W'(size_bytes(size) - 32'd1);
        misalign = |(off & low_bits);
        full_row = (32'(size) == OFF_W);
    end

endmodule

// File: rtl/sublane_swap.sv
// Module: sublane_swap
// Reverses the low 2^size bytes of a right-aligned value when enabled.
// Assumes the input is already masked to the access width.
module sublane_swap #(
    parameter int ROW_BYTES = 8,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int NSIZES   = OFF_W + 1,
    localparam int DATA_W   = ROW_BYTES * 8
) (
    input  logic              en,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] cand [NSIZES];

    // One reversed candidate per width code.
    for (genvar s = 0; s < NSIZES; s++) begin : g_sz
        for (genvar b = 0; b < ROW_BYTES; b++) begin : g_b
            if (b < (1 << s)) begin : g_in
                assign cand[s][8*b +: 8] = din[8*((1 << s) - 1 - b) +: 8];
            end else begin : g_out
                assign cand[s][8*b +: 8] = 8'h00;
            end
        end
    end

    // Purpose: choose the candidate for this width, or pass through.
    always_comb begin
        dout = en ? cand[size] : din;
    end

endmodule

// File: rtl/sublane_rows.sv
// Module: sublane_rows
// Row storage with one valid bit per row. Reset clears only the valid bits.
// A row whose valid bit is clear reads as zero. Read is combinational.
// Assumes at most one write per cycle.
module sublane_rows #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] store [ROWS];
    logic [ROWS-1:0]   valid;

    // Purpose: track which rows hold data written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (we) begin
            valid[idx] <= 1'b1;
        end
    end

    // Purpose: row data write (no reset needed, gated by valid on read).
    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= wr_data;
        end
    end

    // Purpose: read with zero for rows never written.
    always_comb begin
        rd_data = valid[idx] ? store[idx] : '0;
    end

endmodule

// File: rtl/sublane_mem.sv
// Module: sublane_mem (top)
// Byte-addressed memory of ROWS rows of ROW_BYTES bytes. Serves loads and
// stores of 1..ROW_BYTES bytes. Sub-row stores read-modify-write a row in one
// cycle. Loads return registered, zero-extended data one cycle later.
// Optional byte reversal over the access width. Misaligned requests are refused.
// Assumes one request per cycle on a single port.
module sublane_mem #(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = ROW_W + OFF_W,
    localparam int DATA_W   = ROW_BYTES * 8,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_misalign
);
    logic [ROW_W-1:0]  row;
    logic [SH_W-1:0]   shift;
    logic [DATA_W-1:0] width_mask;
    logic              misalign;
    logic              full_row;
    logic [DATA_W-1:0] cur_row;
    logic [DATA_W-1:0] ld_ext, ld_val;
    logic [DATA_W-1:0] st_in, st_val, new_row;
    logic              do_store, do_load;

    sublane_align #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_align (
        .addr(req_addr), .size(req_size), .row(row), .shift(shift),
        .width_mask(width_mask), .misalign(misalign), .full_row(full_row)
    );

    sublane_rows #(.ROWS(ROWS), .DATA_W(DATA_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .idx(row), .rd_data(cur_row),
        .we(do_store), .wr_data(new_row)
    );

    sublane_swap #(.ROW_BYTES(ROW_BYTES)) u_ld_swap (
        .en(req_swap), .size(req_size), .din(ld_ext), .dout(ld_val)
    );

    sublane_swap #(.ROW_BYTES(ROW_BYTES)) u_st_swap (
        .en(req_swap), .size(req_size), .din(st_in), .dout(st_val)
    );

    // Purpose: accept only aligned requests.
    always_comb begin
        do_store = req_valid && req_write && !misalign;
        do_load  = req_valid && !req_write && !misalign;
    end

    // Purpose: extract load lanes, then merge or replace the row on a store.
    always_comb begin
        ld_ext = (cur_row >> shift) & width_mask;
        st_in  = req_wdata & width_mask;
        if (full_row) begin
            new_row = st_val;
        end else begin
            new_row = (cur_row & ~(width_mask << shift)) | (st_val << shift);
        end
    end

    // Purpose: register load data and the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata    <= '0;
            rsp_misalign <= 1'b0;
        end else begin
            rsp_misalign <= req_valid && misalign;
            if (do_load) begin
                rsp_rdata <= ld_val;
            end
        end
    end

endmodule

// File: rtl/sublane_mem_chk.sv
// Module: sublane_mem_chk
// Port-level properties of sublane_mem, attached with bind below.
module sublane_mem_chk #(
    parameter int ROW_BYTES = 8,
    parameter int ROWS      = 16,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ADDR_W   = ROW_W + OFF_W,
    localparam int DATA_W   = ROW_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_misalign
);
    logic [OFF_W-1:0] lowm;
    logic             bad;

    // Purpose: independent alignment test from the ports.
    always_comb begin
        lowm = OFF_W'((32'd1 << req_size) - 32'd1);
        bad  = (req_addr[OFF_W-1:0] & lowm) != '0;
    end

    p_refuse_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |=> rsp_misalign);

    p_no_false_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && bad) |=> !rsp_misalign);

    p_refused_keeps_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |=> $stable(rsp_rdata));

    p_byte_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !bad && req_size == 2'd0)
        |=> (rsp_rdata[DATA_W-1:8] == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_rdata));

    p_store_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> $stable(rsp_rdata));

endmodule

bind sublane_mem sublane_mem_chk #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_rdata(rsp_rdata),
    .rsp_misalign(rsp_misalign)
);

// File: tb/sim_sublane_mem.sv
// Bench for sublane_mem: directed corners plus seeded random traffic,
// checked against a row model built from the requirements.
module sim_sublane_mem;
    localparam int ROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_swap = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_misalign;

    int errors = 0;
    int checks = 0;
    logic [63:0] model [ROWS];
    logic [63:0] exp_rdata = '0;

    always #4 clk = ~clk;

    sublane_mem u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign)
    );

    function automatic logic [63:0] wmask(input int sz);
        logic [63:0] m = '0;
        for (int b = 0; b < (1 << sz); b++) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] rev(input logic [63:0] v, input int sz);
        logic [63:0] r = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) model[r] = '0;
        exp_rdata = '0;
        check(rsp_rdata == 64'd0, "R6 reset rdata", rsp_rdata, 64'd0);
        check(rsp_misalign == 1'b0, "R6 reset flag", 64'(rsp_misalign), 64'd0);
    endtask

    // Issue one request at a falling edge and check it at the next one.
    task automatic op(input bit wr, input int addr, input int sz, input bit sw,
                      input logic [63:0] wd, input string tag);
        int row = addr / 8;
        int off = addr % 8;
        bit bad = (off % (1 << sz)) != 0;
        logic [63:0] d;
        req_valid = 1'b1; req_write = wr; req_addr = 7'(addr);
        req_size = 2'(sz); req_swap = sw; req_wdata = wd;
        if (!bad && !wr) begin
            d = (model[row] >> (off*8)) & wmask(sz);
            exp_rdata = sw ? rev(d, sz) : d;
        end
        if (!bad && wr) begin
            d = wd & wmask(sz);
            if (sw) d = rev(d, sz);
            model[row] = (model[row] & ~(wmask(sz) << (off*8))) | (d << (off*8));
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_misalign == bad, {tag, " flag"}, 64'(rsp_misalign), 64'(bad));
        check(rsp_rdata == exp_rdata, {tag, " data"}, rsp_rdata, exp_rdata);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        check(rsp_rdata == exp_rdata, tag, rsp_rdata, exp_rdata);
        check(rsp_misalign == 1'b0, tag, 64'(rsp_misalign), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();
        // R6: unwritten row reads zero
        op(0, 8*3, 3, 0, '0, "R6 unwritten");
        // R5: full-row store then load
        op(1, 8*2, 3, 0, 64'h0123_4567_89AB_CDEF, "R5 full store");
        op(0, 8*2, 3, 0, '0, "R5 full load");
        // R4: byte store at offset 3 keeps other lanes, wdata upper bits ignored
        op(1, 8*2 + 3, 0, 0, 64'hFFFF_FFFF_FFFF_FF5A, "R4 byte store");
        op(0, 8*2, 3, 0, '0, "R4 merged row");
        // R3: half load at offset 6, zero-extended
        op(0, 8*2 + 6, 1, 0, '0, "R3 half load");
        // R8 / R7: swapped word store and loads
        op(1, 8*4 + 4, 2, 1, 64'hDEAD_BEEF_1122_3344, "R8 swap store");
        op(0, 8*4, 3, 0, '0, "R8 row view");
        op(0, 8*4 + 4, 2, 1, '0, "R7 swap load");
        op(0, 8*4 + 4, 1, 1, '0, "R7 swap half");
        // R2: misaligned store refused, memory and rdata unchanged
        op(1, 8*2 + 1, 1, 0, 64'hAAAA, "R2 misaligned store");
        op(0, 8*2 + 2, 2, 0, '0, "R2 misaligned load");
        op(0, 8*2, 3, 0, '0, "R2 row intact");
        // R9: idle cycles hold rdata, a store does not disturb it
        idle("R9 idle hold");
        op(1, 8*7, 0, 0, 64'h77, "R9 store hold");
        // R1: same row reached through different addresses
        op(1, 8*5 + 1, 0, 0, 64'hC3, "R1 lane1 store");
        op(0, 8*5, 1, 0, '0, "R1 half via row base");
        op(0, 8*15 + 7, 0, 0, '0, "R1 top row");
        // R10: back-to-back sub-row stores into one row, then load at once
        op(1, 8*9, 1, 0, 64'hBEEF, "R10 store a");
        op(1, 8*9 + 2, 1, 1, 64'h1234, "R10 store b");
        op(1, 8*9 + 4, 2, 0, 64'hCAFEF00D, "R10 store c");
        op(0, 8*9, 3, 0, '0, "R10 load after");
        // Random traffic, back-to-back
        for (int i = 0; i < 600; i++) begin
            op(1'($urandom_range(0, 1)), int'($urandom_range(0, 127)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               {$urandom, $urandom}, "R3/R4 random");
            if ($urandom_range(0, 7) == 0) idle("R9 random idle");
        end
        // R6: reset after writes makes rows read zero again
        do_reset();
        op(0, 8*2, 3, 0, '0, "R6 cleared row");
        op(0, 8*9 + 4, 2, 1, '0, "R6 cleared word");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule